// File: doc/BRIEF.md
# T1 Data-Multiplexed Channel-24 Sync Byte Handler

This block handles the synchronization byte that a T1 data-multiplexed frame carries in payload channel 24. It sits on a parallel channel interface. Each cycle carries one channel word, made of a channel index and an 8-bit data byte. A frame-start strobe marks the start of each frame. The transmit and receive directions each have their own valid, index and data inputs.

On transmit, the block replaces channel 24 with the fixed word `1 0 1 1 1 Y R 0`, sent MSB first. It places a yellow-alarm flag in Y and one auxiliary data bit per frame in R. Together the R bits form an 8 kb/s side channel. On receive, it takes Y and R out of channel 24 and checks the six fixed positions against the expected pattern. It raises a one-cycle error pulse when any fixed bit is wrong and counts these errors in a saturating counter. A clear strobe resets the counter.

The framing bit itself is left unchanged, as in D4 framing. When the enable input is low, channel 24 passes through untouched in both directions.

Top module: `t1dm_sync_byte`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all outputs are zero. This includes `err_count`, `rx_yellow`, `rx_r`, `rx_r_vld` and `sync_err`.
- R2: When `t1dm_en` is 1 and a transmit word has channel index 24, the word leaves on `tx_out_data` one cycle later with bits [7:3] = 10111 and bit [0] = 0. Bit 7 is the first bit on the line.
- R3: In the inserted transmit byte, bit [2] is Y and bit [1] is R. Y and R are the values of `yellow_req` and `tx_r` captured at the last `frame_start`. When `frame_start` is high in the same cycle as the channel-24 word, the live input values are used.
- R4: Words on any channel other than 24 appear on `tx_out_data` or `rx_out_data` one cycle later, unchanged. The matching `*_out_vld` output is the input valid delayed by one cycle.
- R5: When `t1dm_en` is 1, a received channel-24 word produces a one-cycle pulse on `rx_r_vld` one cycle later. In that cycle `rx_r` equals received bit [1] and `rx_yellow` equals received bit [2]. `rx_yellow` then holds its value until the next channel-24 word.
- R6: `sync_err` pulses in the same cycle as `rx_r_vld` if any of received bits 7,6,5,4,3,0 differ from 1,0,1,1,1,0. The values of bits 2 and 1 have no effect on `sync_err`.
- R7: When `t1dm_en` is 0, channel-24 words pass through unchanged in both directions. In that case `rx_r_vld` and `sync_err` stay 0, and `err_count` does not change.
- R8: `err_count` rises by one on the same clock edge that raises each `sync_err` pulse. It stops at 255.
- R9: A high `err_clr` sets `err_count` to 0 on the next edge. A sync error in that same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| t1dm_en | input | 1 | Enables sync-byte insertion and checking |
| frame_start | input | 1 | Frame-start strobe; captures yellow_req and tx_r |
| yellow_req | input | 1 | Yellow-alarm request for transmit Y bit |
| tx_r | input | 1 | Transmit auxiliary bit R |
| tx_vld | input | 1 | Transmit word valid |
| tx_ch | input | 5 | Transmit channel index (1..24) |
| tx_data | input | 8 | Transmit channel byte |
| rx_vld | input | 1 | Receive word valid |
| rx_ch | input | 5 | Receive channel index (1..24) |
| rx_data | input | 8 | Receive channel byte |
| err_clr | input | 1 | Clears the error counter |
| tx_out_vld | output | 1 | Transmit output valid |
| tx_out_data | output | 8 | Transmit byte after insertion |
| rx_out_vld | output | 1 | Receive output valid |
| rx_out_data | output | 8 | Receive byte passed through |
| rx_yellow | output | 1 | Last received Y bit |
| rx_r | output | 1 | Last received R bit |
| rx_r_vld | output | 1 | One-cycle strobe for rx_r |
| sync_err | output | 1 | One-cycle sync-byte mismatch pulse |
| err_count | output | 8 | Saturating sync-error count |

## Verification
Every output is one register stage away from its inputs. The transmit byte, the receive pass-through, `rx_r`, `rx_yellow`, `rx_r_vld`, `sync_err` and the counter update are all due on the first rising edge after the word is presented. `err_clr` likewise takes effect on that first edge. The bench drives each word on a falling edge. It then waits for the next rising edge and samples one nanosecond later, so every check reads the result of exactly one stage. The saturation and clear-priority cases are checked in that same one-edge window.

// File: rtl/t1dm_pkg.sv
package t1dm_pkg;
  localparam int BYTE_W = 8;
  // fixed positions 7..3 and 0 are checked; 2 (Y) and 1 (R) are live
  localparam logic [BYTE_W-1:0] FIX_MASK = 8'b1111_1001;
  localparam logic [BYTE_W-1:0] FIX_PAT  = 8'b1011_1000;
  localparam int Y_POS = 2;
  localparam int R_POS = 1;

  function automatic logic [BYTE_W-1:0] build_sync(input logic y, input logic r);
    logic [BYTE_W-1:0] b;
    b = FIX_PAT;
    b[Y_POS] = y;
    b[R_POS] = r;
    return b;
  endfunction
endpackage

// File: rtl/t1dm_tx_insert.sv
module t1dm_tx_insert #(
  parameter int CH_W    = 5,
  parameter int SYNC_CH = 24
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        frame_start,
  input  logic                        yellow_req,
  input  logic                        aux_bit,
  input  logic                        in_vld,
  input  logic [CH_W-1:0]             in_ch,
  input  logic [t1dm_pkg::BYTE_W-1:0] in_data,
  output logic                        out_vld,
  output logic [t1dm_pkg::BYTE_W-1:0] out_data
);
  import t1dm_pkg::*;

  logic y_hold, r_hold;
  logic y_eff, r_eff;
  logic hit;

  assign y_eff = frame_start ? yellow_req : y_hold;
  assign r_eff = frame_start ? aux_bit    : r_hold;
  assign hit   = in_vld && en && (in_ch == CH_W'(SYNC_CH));

  always_ff @(posedge clk) begin
    if (rst) begin
      y_hold   <= 1'b0;
      r_hold   <= 1'b0;
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      if (frame_start) begin
        y_hold <= yellow_req;
        r_hold <= aux_bit;
      end
      out_vld  <= in_vld;
      out_data <= hit ? build_sync(y_eff, r_eff) : in_data;
    end
  end
endmodule

// File: rtl/t1dm_rx_check.sv
module t1dm_rx_check #(
  parameter int CH_W    = 5,
  parameter int SYNC_CH = 24
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        in_vld,
  input  logic [CH_W-1:0]             in_ch,
  input  logic [t1dm_pkg::BYTE_W-1:0] in_data,
  output logic                        out_vld,
  output logic [t1dm_pkg::BYTE_W-1:0] out_data,
  output logic                        yellow,
  output logic                        aux_bit,
  output logic                        aux_vld,
  output logic                        err_pulse,
  output logic                        mismatch_now
);
  import t1dm_pkg::*;

  logic hit;

  assign hit          = in_vld && en && (in_ch == CH_W'(SYNC_CH));
  assign mismatch_now = hit && ((in_data & FIX_MASK) != FIX_PAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_data  <= '0;
      yellow    <= 1'b0;
      aux_bit   <= 1'b0;
      aux_vld   <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      out_vld   <= in_vld;
      out_data  <= in_data;
      aux_vld   <= hit;
      err_pulse <= mismatch_now;
      if (hit) begin
        yellow  <= in_data[Y_POS];
        aux_bit <= in_data[R_POS];
      end
    end
  end
endmodule

// File: rtl/t1dm_err_counter.sv
module t1dm_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (inc && (count != CNT_MAX)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/t1dm_sync_byte.sv
module t1dm_sync_byte #(
  parameter int CH_W    = 5,
  parameter int SYNC_CH = 24,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             t1dm_en,
  input  logic             frame_start,
  input  logic             yellow_req,
  input  logic             tx_r,
  input  logic             tx_vld,
  input  logic [CH_W-1:0]  tx_ch,
  input  logic [7:0]       tx_data,
  input  logic             rx_vld,
  input  logic [CH_W-1:0]  rx_ch,
  input  logic [7:0]       rx_data,
  input  logic             err_clr,
  output logic             tx_out_vld,
  output logic [7:0]       tx_out_data,
  output logic             rx_out_vld,
  output logic [7:0]       rx_out_data,
  output logic             rx_yellow,
  output logic             rx_r,
  output logic             rx_r_vld,
  output logic             sync_err,
  output logic [CNT_W-1:0] err_count
);
  logic mismatch;

  t1dm_tx_insert #(.CH_W(CH_W), .SYNC_CH(SYNC_CH)) u_tx (
    .clk(clk), .rst(rst), .en(t1dm_en), .frame_start(frame_start),
    .yellow_req(yellow_req), .aux_bit(tx_r), .in_vld(tx_vld),
    .in_ch(tx_ch), .in_data(tx_data), .out_vld(tx_out_vld),
    .out_data(tx_out_data)
  );

  t1dm_rx_check #(.CH_W(CH_W), .SYNC_CH(SYNC_CH)) u_rx (
    .clk(clk), .rst(rst), .en(t1dm_en), .in_vld(rx_vld), .in_ch(rx_ch),
    .in_data(rx_data), .out_vld(rx_out_vld), .out_data(rx_out_data),
    .yellow(rx_yellow), .aux_bit(rx_r), .aux_vld(rx_r_vld),
    .err_pulse(sync_err), .mismatch_now(mismatch)
  );

  t1dm_err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(mismatch), .clr(err_clr), .count(err_count)
  );
endmodule

// File: rtl/t1dm_sync_byte_chk.sv
module t1dm_sync_byte_chk #(
  parameter int CH_W    = 5,
  parameter int SYNC_CH = 24,
  parameter int CNT_W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             t1dm_en,
  input logic             tx_vld,
  input logic [CH_W-1:0]  tx_ch,
  input logic [7:0]       tx_data,
  input logic             rx_vld,
  input logic [CH_W-1:0]  rx_ch,
  input logic             err_clr,
  input logic [7:0]       tx_out_data,
  input logic             rx_r_vld,
  input logic             sync_err,
  input logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  assert_tx_pattern_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_vld && t1dm_en && tx_ch == CH_W'(SYNC_CH)) |=> ((tx_out_data & 8'hF9) == 8'hB8));

  assert_tx_passthru_R4: assert property (@(posedge clk) disable iff (rst)
    (tx_vld && tx_ch != CH_W'(SYNC_CH)) |=> (tx_out_data == $past(tx_data)));

  assert_tx_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_vld && !t1dm_en) |=> (tx_out_data == $past(tx_data)));

  assert_rvld_source_R5: assert property (@(posedge clk) disable iff (rst)
    rx_r_vld |-> $past(rx_vld && t1dm_en && rx_ch == CH_W'(SYNC_CH)));

  assert_err_with_rvld_R6: assert property (@(posedge clk) disable iff (rst)
    sync_err |-> rx_r_vld);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (err_count == CMAX && !err_clr) |=> (err_count == CMAX));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    err_clr |=> (err_count == '0));
endmodule

bind t1dm_sync_byte t1dm_sync_byte_chk #(.CH_W(CH_W), .SYNC_CH(SYNC_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .t1dm_en(t1dm_en), .tx_vld(tx_vld), .tx_ch(tx_ch),
  .tx_data(tx_data), .rx_vld(rx_vld), .rx_ch(rx_ch), .err_clr(err_clr),
  .tx_out_data(tx_out_data), .rx_r_vld(rx_r_vld), .sync_err(sync_err),
  .err_count(err_count)
);

// File: tb/t1dm_sync_byte_tb.sv
`timescale 1ns/100ps
module t1dm_sync_byte_tb;
  logic       clk = 1'b0;
  logic       rst, t1dm_en, frame_start, yellow_req, tx_r, tx_vld, rx_vld, err_clr;
  logic [4:0] tx_ch, rx_ch;
  logic [7:0] tx_data, rx_data;
  logic       tx_out_vld, rx_out_vld, rx_yellow, rx_r, rx_r_vld, sync_err;
  logic [7:0] tx_out_data, rx_out_data, err_count;

  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  t1dm_sync_byte u_dut (
    .clk(clk), .rst(rst), .t1dm_en(t1dm_en), .frame_start(frame_start),
    .yellow_req(yellow_req), .tx_r(tx_r), .tx_vld(tx_vld), .tx_ch(tx_ch),
    .tx_data(tx_data), .rx_vld(rx_vld), .rx_ch(rx_ch), .rx_data(rx_data),
    .err_clr(err_clr), .tx_out_vld(tx_out_vld), .tx_out_data(tx_out_data),
    .rx_out_vld(rx_out_vld), .rx_out_data(rx_out_data), .rx_yellow(rx_yellow),
    .rx_r(rx_r), .rx_r_vld(rx_r_vld), .sync_err(sync_err), .err_count(err_count)
  );

  // {en, ch[4:0], data[7:0], exp_tx[7:0], exp_err}; Y=1,R=0 latched -> BC
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 5'd24, 8'hB8, 8'hBC, 1'b0},
    {1'b1, 5'd24, 8'hBE, 8'hBC, 1'b0},
    {1'b1, 5'd3,  8'h5A, 8'h5A, 1'b0},
    {1'b1, 5'd24, 8'h38, 8'hBC, 1'b1},
    {1'b1, 5'd24, 8'hB9, 8'hBC, 1'b1},
    {1'b1, 5'd24, 8'h00, 8'hBC, 1'b1},
    {1'b0, 5'd24, 8'h00, 8'h00, 1'b0},
    {1'b1, 5'd1,  8'hFF, 8'hFF, 1'b0},
    {1'b1, 5'd24, 8'h98, 8'hBC, 1'b1},
    {1'b0, 5'd24, 8'h3C, 8'h3C, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic [4:0] ch, input logic [7:0] d);
    @(negedge clk);
    t1dm_en = en; tx_vld = 1'b1; rx_vld = 1'b1;
    tx_ch = ch; rx_ch = ch; tx_data = d; rx_data = d;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic exp_y;
    rst = 1'b1; t1dm_en = 1'b0; frame_start = 1'b0; yellow_req = 1'b0; tx_r = 1'b0;
    tx_vld = 1'b0; rx_vld = 1'b0; err_clr = 1'b0;
    tx_ch = '0; rx_ch = '0; tx_data = '0; rx_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 err_count reset", err_count, 0);
    chk("R1 outputs reset", {tx_out_vld, tx_out_data, rx_out_vld, rx_out_data,
        rx_yellow, rx_r, rx_r_vld, sync_err}, 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 first cycle after reset", {rx_r_vld, sync_err, err_count}, 0);

    // latch Y=1, R=0
    @(negedge clk); frame_start = 1'b1; yellow_req = 1'b1; tx_r = 1'b0;
    @(negedge clk); frame_start = 1'b0; yellow_req = 1'b0; tx_r = 1'b1;

    exp_y = 1'b0;
    foreach (VEC[i]) begin
      logic en; logic [4:0] ch; logic [7:0] d, etx; logic eerr; logic hit;
      {en, ch, d, etx, eerr} = VEC[i];
      hit = en && (ch == 5'd24);
      drive(en, ch, d);
      if (eerr) exp_cnt++;
      if (hit) exp_y = d[2];
      chk(hit ? "R2 R3 tx sync byte" : "R4 R7 tx pass", tx_out_data, etx);
      chk("R4 rx data pass", rx_out_data, d);
      chk("R4 out valids", {tx_out_vld, rx_out_vld}, 2'b11);
      chk("R5 R7 rx_r_vld", rx_r_vld, hit);
      chk("R6 R7 sync_err", sync_err, eerr);
      chk("R5 rx_yellow", rx_yellow, exp_y);
      if (hit) chk("R5 rx_r", rx_r, d[1]);
      chk("R8 R7 err_count", err_count, exp_cnt);
    end

    // R3 same-cycle frame_start bypass: Y=0,R=1 -> BA
    @(negedge clk); frame_start = 1'b1; yellow_req = 1'b0; tx_r = 1'b1;
    drive(1'b1, 5'd24, 8'hB8);
    chk("R3 bypass at frame_start", tx_out_data, 8'hBA);
    @(negedge clk); frame_start = 1'b0; yellow_req = 1'b1; tx_r = 1'b0;
    drive(1'b1, 5'd24, 8'hB8);
    chk("R3 latched between frames", tx_out_data, 8'hBA);

    // R8 saturation
    for (int k = 0; k < 260; k++) drive(1'b1, 5'd24, 8'h00);
    chk("R8 saturates at 255", err_count, 255);
    chk("R6 error pulse at saturation", sync_err, 1);

    // R9 clear
    @(negedge clk); err_clr = 1'b1; tx_vld = 1'b0; rx_vld = 1'b0;
    @(posedge clk); #1;
    chk("R9 clear", err_count, 0);
    drive(1'b1, 5'd24, 8'h00);
    chk("R9 clear beats increment", err_count, 0);
    chk("R9 pulse still seen", sync_err, 1);
    @(negedge clk); err_clr = 1'b0;
    @(posedge clk); #1;
    chk("R8 count after clear", err_count, 1);

    // R7 disabled leaves count alone
    drive(1'b0, 5'd24, 8'h11);
    chk("R7 disabled count", err_count, 1);
    chk("R7 disabled pass", rx_out_data, 8'h11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule